// File: doc/BRIEF.md
# Comma-Aligned Receive Framer

This block sits behind a clock-recovery stage and takes the recovered serial stream one bit per bit clock. It keeps the last ten received bits in a window and watches that window for the 8b/10b comma symbol K28.5 in either running disparity. A comma found while reframing is permitted fixes the symbol boundary. Every later symbol is cut from a free-running bit counter. At each boundary the block presents the ten aligned bits together with a byte-rate clock enable. A valid strobe marks symbols delivered after alignment has been won at least once.

The reframe enable decides whether the boundary may move. While it is low, the window is still decoded on the counter's boundaries, but no comma can move them. This includes alias commas made by line bit errors. After the enable has stayed high for a long run of byte times, the framer becomes stricter. It then needs two commas at the same new phase, one symbol apart, before it moves. A mode output shows this double-byte framing.

The mode controller is a four-state machine. LOCKED: reframing is off. It is entered from any state when the enable is low, and left for SINGLE when the enable is high. SINGLE: any comma realigns. It moves to DOUBLE on the byte time that completes the run. DOUBLE: a comma off the current boundary moves it to PEND. PEND: the first comma has been seen. If the window holds a comma exactly one symbol later, the framer realigns and returns to DOUBLE; otherwise it returns to DOUBLE without moving. A further off-phase comma seen earlier restarts the wait. From LOCKED, the run-length rule leads straight to DOUBLE, in the same way as from SINGLE.

Top module: `comma_framer`

## Requirements
- R1: The window shifts left by one bit per clock, and the newest bit enters at bit 0. A symbol is presented with its first-received bit (bit a) at sym_out[9]. A comma is either 10'b0011111010 or 10'b1100000101 read in that order.
- R2: With the enable high in LOCKED or SINGLE, a comma completing on any clock is a realignment. On that same clock edge, byte_ce and sym_valid assert and sym_out holds the comma. Every later boundary follows ten clocks after the previous one.
- R3: Without a realignment, byte_ce pulses once every ten clocks from reset. It carries the last ten received bits to sym_out, and sym_out is held between pulses.
- R4: sym_valid stays low until the first realignment after reset. From then on it equals byte_ce.
- R5: While reframe_en is low, no comma at any phase changes the boundary.
- R6: When reframe_en has been high for 2048 consecutive boundaries (DBL_BYTES), dbl_mode rises on the clock of the 2048th boundary.
- R7: With dbl_mode high, a single off-phase comma does not move the boundary. Two commas that complete ten clocks apart at the same new phase realign on the second one, and that second comma is output as a valid symbol.
- R8: A low reframe_en clears the boundary run count and drops dbl_mode on the next clock edge.
- R9: While rst_n is low, sym_out, sym_valid, byte_ce and dbl_mode are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_bit | input | 1 | Serial data bit, one per clock |
| reframe_en | input | 1 | High permits the boundary to move |
| sym_out | output | 10 | Aligned symbol, bit a at the top |
| sym_valid | output | 1 | Strobe for a symbol delivered after alignment |
| byte_ce | output | 1 | One-clock pulse at every symbol boundary |
| dbl_mode | output | 1 | High while double-byte framing applies |

## Verification
Two functions can land on the same clock. One is the completion of an off-phase comma. The other is either a boundary from the free counter or a change of the reframe enable. The bench sends short bit slips followed by commas in every mode. As a result, the old-phase boundary fires in the middle of the comma, and the comma then completes a few clocks later. The bench predicts from the requirements whether the boundary moves. It then compares the mixed old-phase symbol and the comma symbol in order. In the same runs, it checks dbl_mode against a run count kept from the sampled enable and the boundary pulses.

// File: rtl/framer_pkg.sv
package framer_pkg;

    localparam int SYM_W = 10;

    // Comma symbol K28.5, bit a at the left, for each running disparity
    localparam logic [SYM_W-1:0] COMMA_RDN = 10'b0011111010;
    localparam logic [SYM_W-1:0] COMMA_RDP = 10'b1100000101;

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_SINGLE = 2'd1,
        ST_DOUBLE = 2'd2,
        ST_PEND   = 2'd3
    } frm_state_t;

    function automatic logic is_comma(input logic [SYM_W-1:0] w);
        return (w == COMMA_RDN) || (w == COMMA_RDP);
    endfunction

endpackage

// File: rtl/framer_shreg.sv
module framer_shreg
    import framer_pkg::*;
#(
    parameter int W = SYM_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_in,
    output logic [W-1:0] win_nxt,
    output logic         comma_hit
);

    logic [W-1:0] sr;

    // Window as it stands once this clock's bit is in
    assign win_nxt   = {sr[W-2:0], bit_in};
    assign comma_hit = is_comma(win_nxt);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else begin
            sr <= win_nxt;
        end
    end

    // R1
    sr_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sr == {$past(sr[W-2:0]), $past(bit_in)});

endmodule

// File: rtl/framer_symcnt.sv
module framer_symcnt
    import framer_pkg::*;
#(
    parameter int W = SYM_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] win_nxt,
    input  logic         realign,
    output logic         at_edge,
    output logic [W-1:0] sym_out,
    output logic         byte_ce,
    output logic         sym_valid
);

    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] cnt;
    logic          aligned;
    logic          boundary;

    assign at_edge  = (cnt == LAST);
    assign boundary = at_edge || realign;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            aligned   <= 1'b0;
            sym_out   <= '0;
            byte_ce   <= 1'b0;
            sym_valid <= 1'b0;
        end else begin
            byte_ce   <= boundary;
            sym_valid <= boundary && (aligned || realign);
            if (realign) begin
                aligned <= 1'b1;
            end
            if (boundary) begin
                cnt     <= '0;
                sym_out <= win_nxt;
            end else begin
                cnt     <= cnt + 1'b1;
            end
        end
    end

    // R2
    realign_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> byte_ce && sym_valid && (sym_out == $past(win_nxt)));

    // R3
    no_early_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!realign && !at_edge) |=> !byte_ce);

    // R3
    sym_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_ce |-> $stable(sym_out));

    // R4
    valid_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |-> byte_ce);

endmodule

// File: rtl/framer_mode_fsm.sv
module framer_mode_fsm
    import framer_pkg::*;
#(
    parameter int W         = SYM_W,
    parameter int DBL_BYTES = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reframe_en,
    input  logic comma_hit,
    input  logic at_edge,
    output logic realign,
    output logic dbl_mode
);

    localparam int BW = (DBL_BYTES > 2) ? $clog2(DBL_BYTES) : 1;
    localparam int PW = $clog2(W);
    localparam logic [BW-1:0] RUN_LAST  = BW'(DBL_BYTES - 1);
    localparam logic [PW-1:0] PEND_LAST = PW'(W - 1);

    frm_state_t    state, nxt;
    logic [BW-1:0] bcnt;
    logic [PW-1:0] pcnt;
    logic          bcnt_full;
    logic          off_comma;
    logic          pend_last;
    logic          boundary;

    assign bcnt_full = (bcnt == RUN_LAST);
    assign off_comma = comma_hit && !at_edge;
    assign pend_last = (pcnt == PEND_LAST);
    assign boundary  = at_edge || realign;

    // State register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_LOCKED;
            bcnt  <= '0;
            pcnt  <= '0;
        end else begin
            state <= nxt;
            if (!reframe_en) begin
                bcnt <= '0;
            end else if (boundary && !bcnt_full) begin
                bcnt <= bcnt + 1'b1;
            end
            if (state == ST_DOUBLE && off_comma) begin
                pcnt <= '0;
            end else if (state == ST_PEND) begin
                if (off_comma && !pend_last) begin
                    pcnt <= '0;
                end else begin
                    pcnt <= pcnt + 1'b1;
                end
            end
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        if (!reframe_en) begin
            nxt = ST_LOCKED;
        end else begin
            unique case (state)
                ST_LOCKED, ST_SINGLE: nxt = (boundary && bcnt_full) ? ST_DOUBLE : ST_SINGLE;
                ST_DOUBLE:            nxt = off_comma ? ST_PEND : ST_DOUBLE;
                ST_PEND:              nxt = pend_last ? ST_DOUBLE : ST_PEND;
                default:              nxt = ST_LOCKED;
            endcase
        end
    end

    // Outputs
    always_comb begin
        realign  = 1'b0;
        dbl_mode = 1'b0;
        unique case (state)
            ST_LOCKED, ST_SINGLE: realign = reframe_en && comma_hit;
            ST_DOUBLE: dbl_mode = 1'b1;
            ST_PEND: begin
                dbl_mode = 1'b1;
                realign  = reframe_en && comma_hit && pend_last;
            end
            default: realign = 1'b0;
        endcase
    end

    // R8
    dbl_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reframe_en |=> !dbl_mode);

    // R6
    dbl_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbl_mode) |-> $past(reframe_en) && $past(bcnt_full));

    // R7
    double_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_mode && realign) |-> $past(comma_hit, 10));

endmodule

// File: rtl/comma_framer.sv
module comma_framer
    import framer_pkg::*;
#(
    parameter int DBL_BYTES = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_bit,
    input  logic             reframe_en,
    output logic [SYM_W-1:0] sym_out,
    output logic             sym_valid,
    output logic             byte_ce,
    output logic             dbl_mode
);

    logic [SYM_W-1:0] win_nxt;
    logic             comma_hit;
    logic             at_edge;
    logic             realign;

    framer_shreg #(.W(SYM_W)) u_shreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_in    (ser_bit),
        .win_nxt   (win_nxt),
        .comma_hit (comma_hit)
    );

    framer_mode_fsm #(.W(SYM_W), .DBL_BYTES(DBL_BYTES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .reframe_en (reframe_en),
        .comma_hit  (comma_hit),
        .at_edge    (at_edge),
        .realign    (realign),
        .dbl_mode   (dbl_mode)
    );

    framer_symcnt #(.W(SYM_W)) u_symcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_nxt   (win_nxt),
        .realign   (realign),
        .at_edge   (at_edge),
        .sym_out   (sym_out),
        .byte_ce   (byte_ce),
        .sym_valid (sym_valid)
    );

    // R5
    alias_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reframe_en && !at_edge) |=> !byte_ce);

endmodule

// File: tb/comma_framer_test.sv
`timescale 1ns/1ps
module comma_framer_test;

    localparam int DBL = 2048;
    localparam logic [9:0] CRN  = 10'b0011111010;
    localparam logic [9:0] CRP  = 10'b1100000101;
    localparam logic [9:0] DA   = 10'b0101010101;
    localparam logic [9:0] DB   = 10'b0110011001;
    localparam logic [9:0] DC   = 10'b1001100110;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_bit = 1'b0;
    logic       reframe_en = 1'b1;
    logic [9:0] sym_out;
    logic       sym_valid;
    logic       byte_ce;
    logic       dbl_mode;

    comma_framer #(.DBL_BYTES(DBL)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_bit    (ser_bit),
        .reframe_en (reframe_en),
        .sym_out    (sym_out),
        .sym_valid  (sym_valid),
        .byte_ce    (byte_ce),
        .dbl_mode   (dbl_mode)
    );

    always #2 clk = ~clk;

    int         checks = 0;
    int         failures = 0;
    logic [9:0] exp_q[$];
    logic [9:0] hist = '0;
    int         ph = 0;
    bit         aligned_m = 0;
    bit         ce_flag = 0;
    bit         ce_lat = 0;
    bit         en_q = 0;
    int         run = 0;
    bit         done = 0;
    bit         finished = 0;

    task automatic note(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, expv, $time);
        end
    endtask

    // Drive one bit now and update the boundary model (R2, R3, R4)
    task automatic put_bit(input logic b, input bit rl);
        ser_bit = b;
        hist = {hist[8:0], b};
        ce_flag = 0;
        if (rl || ph == 9) begin
            ce_flag = 1;
            if (aligned_m || rl) exp_q.push_back(hist);
            if (rl) aligned_m = 1;
            ph = 0;
        end else begin
            ph++;
        end
    endtask

    task automatic send_bit(input logic b, input bit rl);
        @(negedge clk);
        put_bit(b, rl);
    endtask

    // Bit a (sym[9]) goes first
    task automatic send_sym(input logic [9:0] s, input bit rl);
        for (int i = 9; i >= 0; i--) send_bit(s[i], rl && (i == 0));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        ce_lat <= ce_flag;
        en_q   <= rst_n ? reframe_en : 1'b0;
    end

    // Monitor: scoreboard pops on every valid symbol
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (byte_ce || ce_lat) note(byte_ce == ce_lat, "R3 byte_ce", byte_ce, ce_lat);
            if (sym_valid) begin
                if (exp_q.size() == 0) begin
                    note(0, "R4 unexpected sym_valid", sym_out, 0);
                end else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    note(sym_out == e, "R2/R5/R7 symbol", sym_out, e);
                end
            end
            if (!en_q) run = 0;
            else if (byte_ce) run++;
            if (byte_ce || dbl_mode) note(dbl_mode == (en_q && run >= DBL), "R6/R8 dbl_mode", dbl_mode, (en_q && run >= DBL));
        end
    end

    initial begin
        // R9 reset state
        repeat (3) @(negedge clk);
        note(sym_out == '0 && !sym_valid && !byte_ce && !dbl_mode, "R9 reset outputs",
             {sym_valid, byte_ce, dbl_mode}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        put_bit(1'b0, 0);

        // R1 R2 R4: junk, negative-disparity comma at an odd phase, data
        for (int i = 0; i < 3; i++) send_bit(1'b0, 0);
        send_sym(CRN, 1);
        send_sym(DA, 0); send_sym(DB, 0); send_sym(DC, 0);

        // R1 R2: four-bit slip, positive-disparity comma realigns
        send_bit(1'b0, 0); send_bit(1'b1, 0); send_bit(1'b0, 0); send_bit(1'b1, 0);
        send_sym(CRP, 1);
        send_sym(DA, 0); send_sym(DB, 0);

        // R5: enable low, alias comma must not move the boundary
        reframe_en = 1'b0;
        send_bit(1'b0, 0); send_bit(1'b1, 0); send_bit(1'b1, 0);
        send_sym(CRN, 0);
        send_sym(DA, 0); send_sym(DB, 0); send_sym(DC, 0);

        // R6: long run with the enable high
        reframe_en = 1'b1;
        for (int k = 0; k < DBL + 60; k++) send_sym(DA, 0);
        note(dbl_mode == 1'b1, "R6 double mode entered", dbl_mode, 1);

        // R7: single off-phase comma in double mode does not move
        send_bit(1'b1, 0); send_bit(1'b0, 0); send_bit(1'b1, 0);
        send_sym(CRN, 0);
        send_sym(DA, 0); send_sym(DB, 0); send_sym(DC, 0); send_sym(DA, 0);

        // R7: two commas one symbol apart at a new phase move it
        send_bit(1'b0, 0); send_bit(1'b1, 0);
        send_sym(CRN, 0);
        send_sym(CRN, 1);
        send_sym(DB, 0); send_sym(DC, 0); send_sym(DA, 0);

        // R8: enable low drops double mode on the next edge
        reframe_en = 1'b0;
        send_sym(DA, 0);
        note(dbl_mode == 1'b0, "R8 double mode left", dbl_mode, 0);
        send_sym(DB, 0);

        for (int i = 0; i < 12; i++) send_bit(1'b0, 0);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        note(exp_q.size() == 0, "R2/R4 missing symbols", exp_q.size(), 0);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        finish_run();
    end

endmodule